// File: doc/BRIEF.md
# Two-Stage Codec Chain Host Sequencer

This block sits on the host side of a serial link that runs through a daisy chain of codec serial ports. Each word that leaves the chain carries a frame sync. That frame sync tells the sequencer that a new received word is starting. It also tells the sequencer to start pushing the next transmit word into the head of the chain. On each sampling event the chain produces one frame per device, so the default of two devices gives two frames per event.

After reset the sequencer spends three sampling events on set-up, writing one control register per event in every device. It writes the clocking register first, then the power register, then the mode register. The mode write carries the chain length and switches the devices to data mode. From then on, every frame carries a 16-bit DAC sample taken from a FIFO-style input, or zero when none is waiting. Every frame received in data mode is reported as an ADC word labelled with the device it came from.

Words are always issued far device first. The word for the last device in the chain therefore travels furthest, and all devices latch their words at the same moment.

Top module: `cascade_cfg_seq`

## Requirements
- R1: While reset is held and until the first frame sync arrives, txFrame, txBit, dacPop, adcValid and cfgDone are all 0.
- R2: frameIn high in cycle t produces txFrame high for the single cycle t+1. The 16-bit word goes out on txBit most significant bit first in cycles t+1 to t+16. txBit is 0 in every cycle that carries no word bit.
- R3: A control word has bit 15 = 1 (control), bit 14 = 0 (write), bits 13:11 = device address, bits 10:8 = register select, and bits 7:0 = register value.
- R4: Within one set-up event, the k-th frame (k = 0, 1, ...) carries device address NUM_DEV-1-k. With two devices, the first word carries address 1 (far device) and the second carries address 0.
- R5: The set-up events go in a fixed order: register select 1 (clocking) in the first event, select 2 (power) in the second, select 0 (mode) in the third. Each event writes the same register in every device. All later frames are data frames.
- R6: The register values are fixed. Clocking is 0x1B: divider code 0 (divide by 1) in bits 7:5, serial clock code 3 (half rate) in bits 4:3, sample rate code 3 (divide by 256) in bits 1:0. Power is 0x07: ADC, DAC and reference enables in bits 0, 1 and 2. Mode carries NUM_DEV in bits 7:5 and the data-mode bit in bit 0, which gives 0x41 for two devices.
- R7: cfgDone rises in the cycle after the last bit of the final mode-register word and then stays high until reset.
- R8: On a data-mode frame sync with dacValid high, dacPop is high in that same cycle and dacData is sent unchanged. dacPop is 0 in every other cycle, and dacValid has no effect during set-up.
- R9: On a data-mode frame sync with dacValid low, the word sent is 0x0000 and nothing is popped.
- R10: rxBit is sampled MSB first from the frameIn cycle t through t+15. For frames that start in data mode, adcValid is high for the single cycle t+16 with the word on adcData. adcDev is NUM_DEV for the first frame of an event and counts down to 1. No adcValid appears for set-up frames.
- R11: Frame syncs spaced exactly 16 cycles apart give a continuous bit stream on txBit, with no idle cycle between words, and every word is still correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frameIn | input | 1 | Frame sync returned from the chain tail |
| rxBit | input | 1 | Serial data from the chain tail |
| txFrame | output | 1 | Frame sync to the chain head |
| txBit | output | 1 | Serial data to the chain head |
| dacValid | input | 1 | A DAC sample is waiting |
| dacData | input | 16 | The waiting DAC sample |
| dacPop | output | 1 | Takes the waiting DAC sample |
| adcValid | output | 1 | A received ADC word is on adcData |
| adcDev | output | 2 | Device index (1..NUM_DEV) of the ADC word |
| adcData | output | 16 | Received ADC word |
| cfgDone | output | 1 | Set-up complete, data mode active |

## Verification
The hardest case to reach is a frame sync that lands in the exact cycle where the previous word puts out its last bit. This matters most at the boundary where the final mode-register word ends and the first data word is loaded. In that cycle the done flag, the phase change, the transmit reload and the receive restart all happen together. The stimulus mixes random gaps of zero to three idle cycles with a directed run of strictly back-to-back frames. This reaches the boundary both with and without a gap. Expected serial words, timing and labels come from bench functions.

// File: rtl/cascade_seq_pkg.sv
package cascade_seq_pkg;

  localparam int WORD_W = 16;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 3;
  localparam int VAL_W  = 8;

  // register selects
  localparam logic [SEL_W-1:0] SEL_MODE  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CLOCK = 3'd1;
  localparam logic [SEL_W-1:0] SEL_POWER = 3'd2;

  // clocking: divider code 0 (/1), serial clock code 3 (half rate), rate code 3 (/256)
  localparam logic [2:0] CLK_DIV_CODE  = 3'd0;
  localparam logic [1:0] SCLK_CODE     = 2'd3;
  localparam logic [1:0] RATE_CODE     = 2'd3;
  localparam logic [VAL_W-1:0] CLOCK_VAL = {CLK_DIV_CODE, SCLK_CODE, 1'b0, RATE_CODE};

  // power: reference, DAC, ADC enables
  localparam logic [VAL_W-1:0] POWER_VAL = 8'b0000_0111;

  typedef enum logic [1:0] {
    PH_CLOCK = 2'd0,
    PH_POWER = 2'd1,
    PH_MODE  = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;

  typedef struct packed {
    logic              loadTx;
    logic              isData;
    logic              useSample;
    logic [ADDR_W-1:0] devAddr;
    logic [SEL_W-1:0]  regSel;
    logic [VAL_W-1:0]  regVal;
    logic              rxStart;
    logic              rxIsAdc;
    logic [ADDR_W-1:0] rxDev;
  } ctrl_strobe_t;

  function automatic logic [WORD_W-1:0] makeCtrlWord(
      input logic [ADDR_W-1:0] addr,
      input logic [SEL_W-1:0]  sel,
      input logic [VAL_W-1:0]  val);
    return {1'b1, 1'b0, addr, sel, val};
  endfunction

endpackage

// File: rtl/cascade_ctrl.sv
module cascade_ctrl
  import cascade_seq_pkg::*;
#(
  parameter int NUM_DEV = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frameIn,
  input  logic         dacValid,
  input  logic         txEnd,
  output ctrl_strobe_t strobe,
  output logic         dacPop,
  output logic         cfgDone
);

  localparam int SLOT_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_DEV - 1);
  localparam logic [VAL_W-1:0]  MODE_VAL  = {3'(NUM_DEV), 4'b0000, 1'b1};

  phase_e            phase;
  logic [SLOT_W-1:0] slot;
  logic              donePend;
  logic              lastSlot;
  logic              inData;

  assign lastSlot = (slot == LAST_SLOT);
  assign inData   = (phase == PH_DATA);

  always_comb begin
    strobe           = '0;
    strobe.loadTx    = frameIn;
    strobe.isData    = inData;
    strobe.useSample = inData && dacValid;
    strobe.devAddr   = ADDR_W'(NUM_DEV - 1) - ADDR_W'(slot);
    strobe.rxStart   = frameIn;
    strobe.rxIsAdc   = inData;
    strobe.rxDev     = ADDR_W'(NUM_DEV) - ADDR_W'(slot);
    unique case (phase)
      PH_CLOCK: begin strobe.regSel = SEL_CLOCK; strobe.regVal = CLOCK_VAL; end
      PH_POWER: begin strobe.regSel = SEL_POWER; strobe.regVal = POWER_VAL; end
      PH_MODE:  begin strobe.regSel = SEL_MODE;  strobe.regVal = MODE_VAL;  end
      default:  begin strobe.regSel = '0;        strobe.regVal = '0;        end
    endcase
  end

  assign dacPop = frameIn && inData && dacValid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_CLOCK;
      slot     <= '0;
      donePend <= 1'b0;
      cfgDone  <= 1'b0;
    end else begin
      if (frameIn) begin
        slot <= lastSlot ? '0 : slot + 1'b1;
        if (lastSlot && !inData) phase <= phase_e'(phase + 2'd1);
        if (lastSlot && phase == PH_MODE) donePend <= 1'b1;
      end
      if (donePend && txEnd) begin
        cfgDone  <= 1'b1;
        donePend <= 1'b0;
      end
    end
  end

  // R5: the phase only ever steps forward by one
  p_phase_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase) |-> (phase == $past(phase) + 2'd1));

  // R7: done is sticky
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfgDone) |-> cfgDone);

  // R7: done only once data mode has been entered
  p_done_in_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfgDone |-> inData);

  // R4: slot stays within the chain length
  p_slot_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= LAST_SLOT);

endmodule

// File: rtl/cascade_dp.sv
module cascade_dp
  import cascade_seq_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int DEV_W   = $clog2(NUM_DEV + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strobe_t      strobe,
  input  logic              rxBit,
  input  logic [WORD_W-1:0] dacData,
  output logic              txFrame,
  output logic              txBit,
  output logic              txEnd,
  output logic              adcValid,
  output logic [DEV_W-1:0]  adcDev,
  output logic [WORD_W-1:0] adcData
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [WORD_W-1:0] txWord;
  logic [WORD_W-1:0] txShift;
  logic [CNT_W-1:0]  txCnt;
  logic [WORD_W-1:0] rxShift;
  logic [CNT_W-1:0]  rxCnt;
  logic              rxIsAdcQ;
  logic [DEV_W-1:0]  rxDevQ;

  always_comb begin
    if (strobe.isData) txWord = strobe.useSample ? dacData : '0;
    else               txWord = makeCtrlWord(strobe.devAddr, strobe.regSel, strobe.regVal);
  end

  assign txBit   = (txCnt != '0) ? txShift[WORD_W-1] : 1'b0;
  assign txEnd   = (txCnt == ONE_CNT);
  assign adcData = rxShift;

  // transmit shifter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txShift <= '0;
      txCnt   <= '0;
      txFrame <= 1'b0;
    end else begin
      txFrame <= strobe.loadTx;
      if (strobe.loadTx) begin
        txShift <= txWord;
        txCnt   <= FULL_CNT;
      end else if (txCnt != '0) begin
        txShift <= {txShift[WORD_W-2:0], 1'b0};
        txCnt   <= txCnt - 1'b1;
      end
    end
  end

  // receive shifter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxShift  <= '0;
      rxCnt    <= '0;
      rxIsAdcQ <= 1'b0;
      rxDevQ   <= '0;
      adcValid <= 1'b0;
      adcDev   <= '0;
    end else begin
      adcValid <= !strobe.rxStart && (rxCnt == ONE_CNT) && rxIsAdcQ;
      adcDev   <= rxDevQ;
      if (strobe.rxStart) begin
        rxShift  <= {rxShift[WORD_W-2:0], rxBit};
        rxCnt    <= CNT_W'(WORD_W - 1);
        rxIsAdcQ <= strobe.rxIsAdc;
        rxDevQ   <= DEV_W'(strobe.rxDev);
      end else if (rxCnt != '0) begin
        rxShift <= {rxShift[WORD_W-2:0], rxBit};
        rxCnt   <= rxCnt - 1'b1;
      end
    end
  end

  // R10: received words are at least a word apart
  p_adc_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adcValid |=> !adcValid);

  // R10: label within the chain
  p_adc_dev_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adcValid |-> (adcDev >= DEV_W'(1)) && (adcDev <= DEV_W'(NUM_DEV)));

  // R11: the bit counter never exceeds one word
  p_tx_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    txCnt <= FULL_CNT);

endmodule

// File: rtl/cascade_cfg_seq.sv
module cascade_cfg_seq
  import cascade_seq_pkg::*;
#(
  parameter int NUM_DEV = 2,
  localparam int DEV_W  = $clog2(NUM_DEV + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameIn,
  input  logic              rxBit,
  output logic              txFrame,
  output logic              txBit,
  input  logic              dacValid,
  input  logic [WORD_W-1:0] dacData,
  output logic              dacPop,
  output logic              adcValid,
  output logic [DEV_W-1:0]  adcDev,
  output logic [WORD_W-1:0] adcData,
  output logic              cfgDone
);

  ctrl_strobe_t strobe;
  logic         txEnd;

  cascade_ctrl #(.NUM_DEV(NUM_DEV)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frameIn(frameIn), .dacValid(dacValid),
    .txEnd(txEnd), .strobe(strobe), .dacPop(dacPop), .cfgDone(cfgDone)
  );

  cascade_dp #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rxBit(rxBit),
    .dacData(dacData), .txFrame(txFrame), .txBit(txBit), .txEnd(txEnd),
    .adcValid(adcValid), .adcDev(adcDev), .adcData(adcData)
  );

endmodule

// File: tb/cascade_cfg_seq_tb.sv
`timescale 1ns/1ps
module cascade_cfg_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frameIn = 1'b0;
  logic        rxBit = 1'b0;
  logic        dacValid = 1'b0;
  logic [15:0] dacData = '0;
  logic        txFrame, txBit, dacPop, adcValid, cfgDone;
  logic [1:0]  adcDev;
  logic [15:0] adcData;

  always #2.5 clk = ~clk;

  cascade_cfg_seq u_dut (
    .clk(clk), .rst_n(rst_n), .frameIn(frameIn), .rxBit(rxBit),
    .txFrame(txFrame), .txBit(txBit), .dacValid(dacValid), .dacData(dacData),
    .dacPop(dacPop), .adcValid(adcValid), .adcDev(adcDev), .adcData(adcData),
    .cfgDone(cfgDone)
  );

  int checks = 0;
  int errors = 0;
  int cycN = 0;
  int frameNo = 0;
  int doneCyc = 32'h7fffffff;
  bit finished = 0;

  logic [15:0] txExpQ[$];
  int          txCycQ[$];
  string       txReqQ[$];
  logic [15:0] adcExpQ[$];
  logic [1:0]  adcDevQ[$];
  int          adcCycQ[$];

  int          colN = 0;
  logic [15:0] colW = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cycN);
    end
  endtask

  function automatic logic [15:0] expCtrl(input int n);
    int ev = n / 2;
    int s  = n % 2;
    logic [2:0] sel;
    logic [7:0] val;
    case (ev)
      0: begin sel = 3'd1; val = 8'h1B; end
      1: begin sel = 3'd2; val = 8'h07; end
      default: begin sel = 3'd0; val = 8'h41; end
    endcase
    return {1'b1, 1'b0, 3'(1 - s), sel, val};
  endfunction

  task automatic tick(input logic fs, input logic b, input logic dv, input logic [15:0] dd, input logic expPop);
    @(negedge clk);
    cycN++;
    // transmit collector (R2, R11)
    if (txFrame) begin
      chk(colN == 0, "R11 word cut short", 32'(colN), 32'd0);
      if (txCycQ.size() > 0) chk(cycN == txCycQ[0], "R2 txFrame timing", 32'(cycN), 32'(txCycQ[0]));
      else chk(1'b0, "R2 unexpected txFrame", 32'd1, 32'd0);
      colN = 1;
      colW = {15'd0, txBit};
    end else if (colN > 0) begin
      colW = {colW[14:0], txBit};
      colN++;
    end else begin
      chk(txBit == 1'b0, "R2 idle txBit", 32'(txBit), 32'd0);
    end
    if (colN == 16) begin
      if (txExpQ.size() > 0) begin
        chk(colW == txExpQ[0], txReqQ[0], 32'(colW), 32'(txExpQ[0]));
        void'(txExpQ.pop_front()); void'(txCycQ.pop_front()); void'(txReqQ.pop_front());
      end
      colN = 0;
    end
    // received words (R10)
    if (adcValid) begin
      if (adcExpQ.size() > 0) begin
        chk(adcData == adcExpQ[0], "R10 adc data", 32'(adcData), 32'(adcExpQ[0]));
        chk(adcDev == adcDevQ[0], "R10 adc device", 32'(adcDev), 32'(adcDevQ[0]));
        chk(cycN == adcCycQ[0], "R10 adc timing", 32'(cycN), 32'(adcCycQ[0]));
        void'(adcExpQ.pop_front()); void'(adcDevQ.pop_front()); void'(adcCycQ.pop_front());
      end else chk(1'b0, "R10 unexpected adcValid", 32'd1, 32'd0);
    end
    // done flag (R7)
    chk(cfgDone == (cycN >= doneCyc), "R7 cfgDone", 32'(cfgDone), 32'(cycN >= doneCyc));
    frameIn = fs; rxBit = b; dacValid = dv; dacData = dd;
    #1;
    chk(dacPop == expPop, "R8 dacPop", 32'(dacPop), 32'(expPop));
  endtask

  task automatic frame(input int gap, input logic dv, input logic [15:0] dd, input logic [15:0] rw);
    int n = frameNo;
    int s = n % 2;
    int st = cycN + 1;
    bit dataF = (n >= 6);
    if (dataF) begin
      txExpQ.push_back(dv ? dd : 16'h0000);
      txReqQ.push_back(dv ? "R8 dac word" : "R9 zero word");
      adcExpQ.push_back(rw);
      adcDevQ.push_back(2'(2 - s));
      adcCycQ.push_back(st + 16);
    end else begin
      txExpQ.push_back(expCtrl(n));
      txReqQ.push_back("R3 R4 R5 R6 control word");
    end
    txCycQ.push_back(st + 1);
    if (n == 5) doneCyc = st + 17;
    tick(1'b1, rw[15], dv, dd, dataF && dv);
    for (int i = 14; i >= 0; i--) tick(1'b0, rw[i], 1'($urandom), 16'($urandom), 1'b0);
    for (int g = 0; g < gap; g++) tick(1'b0, 1'($urandom), 1'($urandom), 16'($urandom), 1'b0);
    frameNo++;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk({txFrame, txBit, dacPop, adcValid, cfgDone} == 5'b0, "R1 reset outputs",
          32'({txFrame, txBit, dacPop, adcValid, cfgDone}), 32'd0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b1, 16'hABCD, 1'b0);
    chk({txFrame, adcValid, cfgDone} == 3'b0, "R1 idle after reset", 32'({txFrame, adcValid, cfgDone}), 32'd0);
    // set-up frames; R8: dacValid high must be ignored here
    for (int k = 0; k < 6; k++) frame(int'($urandom % 3), 1'b1, 16'($urandom), 16'($urandom));
    // random data frames
    for (int k = 0; k < 30; k++)
      frame(int'($urandom % 4), ($urandom % 4) != 0, 16'($urandom), 16'($urandom));
    // R11: back-to-back run with directed corners (R9 empty FIFO)
    frame(0, 1'b1, 16'hFFFF, 16'h8001);
    frame(0, 1'b0, 16'h1234, 16'hFFFF);
    frame(0, 1'b1, 16'h0000, 16'h0000);
    frame(0, 1'b1, 16'h8001, 16'h7FFE);
    frame(0, 1'b0, 16'hFFFF, 16'h5555);
    for (int k = 0; k < 8; k++) frame(0, 1'($urandom), 16'($urandom), 16'($urandom));
    for (int i = 0; i < 24; i++) tick(1'b0, 1'b0, 1'b0, 16'h0, 1'b0);
    chk(txExpQ.size() == 0, "R2 R11 tx words all seen", 32'(txExpQ.size()), 32'd0);
    chk(adcExpQ.size() == 0, "R10 adc words all seen", 32'(adcExpQ.size()), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule